// File: doc/BRIEF.md
# Interrupt Status Controller with Per-Bit Detection Modes

This block gathers a set of single-bit event sources (for example a clock-loss flag, a new-subcode-block flag and a combined receiver-error flag) into one status word. Each status bit has its own two-bit detection code. The code chooses whether the bit latches on a rising edge, a falling edge or either edge of its source, or simply tracks the source level. A mask word selects which status bits may raise the single active-high interrupt line. All source inputs are synchronous to the block clock.

A second, narrower group of receiver-error flags passes through its own mask. Enabled errors are recorded in a sticky error word. The OR of the enabled errors forms the combined receiver-error source that feeds one status bit. A host reaches everything through a plain register strobe interface. Read data is registered, and reading either status word clears its sticky contents.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status word, sticky error word, interrupt mask, error mask and both mode words are all zero; `irq_o` is low and `reg_rdata_o` is zero.
- R2: The register map is: 0 status (read only), 1 interrupt mask, 2 mode upper bits, 3 mode lower bits, 4 sticky error word (read only), 5 error mask. Read data appears on the clock edge that samples `reg_rd_i`. Writes to addresses 0 and 4 are ignored, and reads of 6 and 7 return zero.
- R3: The detection code of status bit i is {upper[i], lower[i]}. Code 00 sets the bit when its source is high on a clock edge after being low on the previous edge.
- R4: Code 01 sets the bit when its source is low on a clock edge after being high on the previous edge.
- R5: Code 10 sets the bit on a change of its source in either direction.
- R6: Code 11 makes the bit equal to its source as sampled on the last clock edge; reading the status word does not clear it.
- R7: A status read returns the word as it stood before the edge and then clears every edge-mode bit, except a bit whose event is detected on that same edge, which stays set.
- R8: `irq_o` is high exactly when some status bit and its mask bit are both 1. The mask affects only `irq_o` and never the status word.
- R9: Receiver-error bit i is recorded in the sticky error word only while error-mask bit i is 1. A recorded bit stays set until a read of address 4 on which the error is no longer active.
- R10: Status bit RERR_BIT (default 2) is driven by the OR of `evt_src_i[RERR_BIT]` and the masked receiver errors. A masked-out error changes neither the status word nor `irq_o`.
- R11: The edge history of every source resets low, so a source held high through reset counts as a rising edge on the first clock after reset.
- R12: `reg_rdata_o` holds its value on every edge where no read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| evt_src_i | input | NUM_SRC | Event sources, one per status bit |
| rerr_i | input | RERR_W | Live receiver-error flags |
| irq_o | output | 1 | Interrupt, active high |

## Verification
On every cycle the embedded properties check the rising, falling and level detection rules for each status bit. They also check that an edge-mode bit drops after a read that saw no source change, that a masked-off error never enters the sticky word, that a fully masked controller keeps the interrupt low, and that read data holds between reads. The directed scenarios cover what the properties cannot see. These are: the register map and the ignored writes to read-only words, the either-edge code, a read racing a fresh event on the same edge, the sticky error word re-latching while its error persists, the error mask gating the combined source, and a source held high through reset.

// File: rtl/isc_pkg.sv
package isc_pkg;

  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 3'd0,
    A_IMASK  = 3'd1,
    A_MODEHI = 3'd2,
    A_MODELO = 3'd3,
    A_ERRSTK = 3'd4,
    A_EMASK  = 3'd5,
    A_RSVD6  = 3'd6,
    A_RSVD7  = 3'd7
  } isc_addr_e;

  typedef enum logic [1:0] {
    DET_RISE  = 2'b00,
    DET_FALL  = 2'b01,
    DET_BOTH  = 2'b10,
    DET_LEVEL = 2'b11
  } det_mode_e;

endpackage

// File: rtl/isc_edge_cell.sv
module isc_edge_cell
  import isc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_i,
  input  logic [1:0] mode_i,
  input  logic       clr_i,
  output logic       stat_o
);

  logic      src_q;
  logic      rise;
  logic      fall;
  logic      hit;
  det_mode_e mode;

  assign mode = det_mode_e'(mode_i);
  assign rise = src_i & ~src_q;
  assign fall = ~src_i & src_q;

  always_comb begin
    unique case (mode)
      DET_RISE:  hit = rise;
      DET_FALL:  hit = fall;
      DET_BOTH:  hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  // Source history resets low on purpose (see R11).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= 1'b0;
    else        src_q <= src_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 stat_o <= 1'b0;
    else if (mode == DET_LEVEL) stat_o <= src_i;
    else if (hit)               stat_o <= 1'b1;
    else if (clr_i)             stat_o <= 1'b0;
  end

  // R3
  rise_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00 && src_i && !src_q) |=> stat_o);

  // R4
  fall_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01 && !src_i && src_q) |=> stat_o);

  // R6
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b11) |=> (stat_o == $past(src_i)));

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && mode_i != 2'b11 && (src_i == src_q)) |=> !stat_o);

endmodule

// File: rtl/isc_rerr_agg.sv
module isc_rerr_agg #(
  parameter int unsigned RERR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RERR_W-1:0] err_i,
  input  logic [RERR_W-1:0] emask_i,
  input  logic              clr_i,
  output logic [RERR_W-1:0] stick_o,
  output logic              comb_o
);

  logic [RERR_W-1:0] live;

  assign live   = err_i & emask_i;
  assign comb_o = |live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stick_o <= '0;
    else if (clr_i) stick_o <= live;
    else            stick_o <= stick_o | live;
  end

  for (genvar g = 0; g < RERR_W; g++) begin : g_chk
    // R9
    rerr_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!emask_i[g] && !stick_o[g]) |=> !stick_o[g]);
  end

endmodule

// File: rtl/isc_regfile.sv
module isc_regfile
  import isc_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned RERR_W  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] stat_i,
  input  logic [RERR_W-1:0]  stick_i,
  output logic [NUM_SRC-1:0] imask_o,
  output logic [NUM_SRC-1:0] mode_hi_o,
  output logic [NUM_SRC-1:0] mode_lo_o,
  output logic [RERR_W-1:0]  emask_o,
  output logic               stat_clr_o,
  output logic               stick_clr_o,
  output logic [DATA_W-1:0]  rdata_o
);

  isc_addr_e         addr;
  logic [DATA_W-1:0] stat_ext;
  logic [DATA_W-1:0] stick_ext;
  logic [DATA_W-1:0] imask_ext;
  logic [DATA_W-1:0] hi_ext;
  logic [DATA_W-1:0] lo_ext;
  logic [DATA_W-1:0] emask_ext;
  logic [DATA_W-1:0] rd_mux;

  assign addr = isc_addr_e'(addr_i);

  always_comb begin
    stat_ext  = '0;
    stick_ext = '0;
    imask_ext = '0;
    hi_ext    = '0;
    lo_ext    = '0;
    emask_ext = '0;
    stat_ext[NUM_SRC-1:0]  = stat_i;
    stick_ext[RERR_W-1:0]  = stick_i;
    imask_ext[NUM_SRC-1:0] = imask_o;
    hi_ext[NUM_SRC-1:0]    = mode_hi_o;
    lo_ext[NUM_SRC-1:0]    = mode_lo_o;
    emask_ext[RERR_W-1:0]  = emask_o;
  end

  always_comb begin
    unique case (addr)
      A_STATUS: rd_mux = stat_ext;
      A_IMASK:  rd_mux = imask_ext;
      A_MODEHI: rd_mux = hi_ext;
      A_MODELO: rd_mux = lo_ext;
      A_ERRSTK: rd_mux = stick_ext;
      A_EMASK:  rd_mux = emask_ext;
      default:  rd_mux = '0;
    endcase
  end

  assign stat_clr_o  = rd_i && (addr == A_STATUS);
  assign stick_clr_o = rd_i && (addr == A_ERRSTK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask_o   <= '0;
      mode_hi_o <= '0;
      mode_lo_o <= '0;
      emask_o   <= '0;
    end else if (wr_i) begin
      unique case (addr)
        A_IMASK:  imask_o   <= wdata_i[NUM_SRC-1:0];
        A_MODEHI: mode_hi_o <= wdata_i[NUM_SRC-1:0];
        A_MODELO: mode_lo_o <= wdata_i[NUM_SRC-1:0];
        A_EMASK:  emask_o   <= wdata_i[RERR_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_o));

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import isc_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_SRC  = 8,
  parameter int unsigned RERR_W   = 7,
  parameter int unsigned RERR_BIT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [2:0]         reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic [NUM_SRC-1:0] evt_src_i,
  input  logic [RERR_W-1:0]  rerr_i,
  output logic               irq_o
);

  logic [NUM_SRC-1:0] imask;
  logic [NUM_SRC-1:0] mode_hi;
  logic [NUM_SRC-1:0] mode_lo;
  logic [RERR_W-1:0]  emask;
  logic [RERR_W-1:0]  stick;
  logic [NUM_SRC-1:0] stat;
  logic [NUM_SRC-1:0] src_m;
  logic               stat_clr;
  logic               stick_clr;
  logic               rerr_comb;

  isc_regfile #(
    .DATA_W  (DATA_W),
    .NUM_SRC (NUM_SRC),
    .RERR_W  (RERR_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_i        (reg_wr_i),
    .rd_i        (reg_rd_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .stat_i      (stat),
    .stick_i     (stick),
    .imask_o     (imask),
    .mode_hi_o   (mode_hi),
    .mode_lo_o   (mode_lo),
    .emask_o     (emask),
    .stat_clr_o  (stat_clr),
    .stick_clr_o (stick_clr),
    .rdata_o     (reg_rdata_o)
  );

  isc_rerr_agg #(
    .RERR_W (RERR_W)
  ) u_rerr (
    .clk     (clk),
    .rst_n   (rst_n),
    .err_i   (rerr_i),
    .emask_i (emask),
    .clr_i   (stick_clr),
    .stick_o (stick),
    .comb_o  (rerr_comb)
  );

  always_comb begin
    src_m           = evt_src_i;
    src_m[RERR_BIT] = evt_src_i[RERR_BIT] | rerr_comb;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
    isc_edge_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src_m[g]),
      .mode_i ({mode_hi[g], mode_lo[g]}),
      .clr_i  (stat_clr),
      .stat_o (stat[g])
    );
  end

  assign irq_o = |(stat & imask);

  // R8
  irq_masked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imask == '0) |-> !irq_o);

endmodule

// File: tb/irq_status_ctrl_tb_top.sv
module irq_status_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] evt_src = '0;
  logic [6:0] rerr_in = '0;
  logic       irq;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  irq_status_ctrl dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr),
    .reg_rd_i    (reg_rd),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .evt_src_i   (evt_src),
    .rerr_i      (rerr_in),
    .irq_o       (irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp=<100000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clean();
    logic [7:0] d;
    evt_src = '0; rerr_in = '0;
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    step(2);
    rd(3'd0, d); rd(3'd4, d);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 rdata", reg_rdata, 8'h00);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk($sformatf("R1 reg%0d", a), d, 8'h00);
    end
  endtask

  task automatic t_regmap();
    logic [7:0] d;
    wr(3'd1, 8'hA5); rd(3'd1, d); chk("R2 imask", d, 8'hA5);
    wr(3'd2, 8'h3C); rd(3'd2, d); chk("R2 modehi", d, 8'h3C);
    wr(3'd3, 8'h0F); rd(3'd3, d); chk("R2 modelo", d, 8'h0F);
    wr(3'd5, 8'hD5); rd(3'd5, d); chk("R2 emask", d, 8'h55);
    wr(3'd0, 8'hFF); rd(3'd0, d); chk("R2 status ro", d, 8'h00);
    wr(3'd4, 8'hFF); rd(3'd4, d); chk("R2 errstk ro", d, 8'h00);
    rd(3'd6, d); chk("R2 unmapped", d, 8'h00);
    wr(3'd5, 8'h00); wr(3'd1, 8'hFF);
    clean();
    chk("R2 irq idle", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_rise();
    logic [7:0] d;
    @(negedge clk); evt_src[0] = 1'b1;
    @(negedge clk);
    chk("R3 irq on rise", {7'd0, irq}, 8'h01);
    rd(3'd0, d); chk("R3 status", d, 8'h01);
    rd(3'd0, d); chk("R3 no new edge", d, 8'h00);
    evt_src[0] = 1'b0; step(2);
    rd(3'd0, d); chk("R3 fall ignored", d, 8'h00);
  endtask

  task automatic t_fall();
    logic [7:0] d;
    wr(3'd3, 8'h02);
    evt_src[1] = 1'b1; step(2);
    rd(3'd0, d); chk("R4 rise ignored", d, 8'h00);
    evt_src[1] = 1'b0; step(1);
    chk("R4 irq on fall", {7'd0, irq}, 8'h01);
    rd(3'd0, d); chk("R4 status", d, 8'h02);
    clean();
  endtask

  task automatic t_both();
    logic [7:0] d;
    wr(3'd2, 8'h08);
    evt_src[3] = 1'b1; step(2);
    rd(3'd0, d); chk("R5 rise", d, 8'h08);
    evt_src[3] = 1'b0; step(2);
    rd(3'd0, d); chk("R5 fall", d, 8'h08);
    rd(3'd0, d); chk("R5 cleared", d, 8'h00);
    clean();
  endtask

  task automatic t_level();
    logic [7:0] d;
    wr(3'd2, 8'h10); wr(3'd3, 8'h10);
    evt_src[4] = 1'b1; step(1);
    chk("R6 irq level", {7'd0, irq}, 8'h01);
    rd(3'd0, d); chk("R6 level set", d, 8'h10);
    rd(3'd0, d); chk("R6 not cleared", d, 8'h10);
    evt_src[4] = 1'b0; step(1);
    chk("R6 irq follows", {7'd0, irq}, 8'h00);
    rd(3'd0, d); chk("R6 level low", d, 8'h00);
    clean();
  endtask

  task automatic t_rdclr();
    logic [7:0] d;
    @(negedge clk);
    evt_src[0] = 1'b1; reg_rd = 1'b1; reg_addr = 3'd0;
    @(negedge clk);
    reg_rd = 1'b0;
    chk("R7 read sees old", reg_rdata, 8'h00);
    rd(3'd0, d); chk("R7 event kept", d, 8'h01);
    rd(3'd0, d); chk("R7 then cleared", d, 8'h00);
    clean();
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(3'd1, 8'h00);
    evt_src[5] = 1'b1; step(2);
    chk("R8 masked irq", {7'd0, irq}, 8'h00);
    wr(3'd1, 8'h20);
    chk("R8 unmasked irq", {7'd0, irq}, 8'h01);
    rd(3'd0, d); chk("R8 status unaffected", d, 8'h20);
    chk("R8 irq after clear", {7'd0, irq}, 8'h00);
    wr(3'd1, 8'hFF);
    clean();
  endtask

  task automatic t_rerr();
    logic [7:0] d;
    wr(3'd5, 8'h00);
    rerr_in = 7'h01; step(2);
    rd(3'd4, d); chk("R9 masked not recorded", d, 8'h00);
    rd(3'd0, d); chk("R10 masked no status", d, 8'h00);
    chk("R10 masked no irq", {7'd0, irq}, 8'h00);
    wr(3'd5, 8'h01); step(1);
    chk("R10 irq from rerr", {7'd0, irq}, 8'h01);
    rd(3'd0, d); chk("R10 status bit2", d, 8'h04);
    rd(3'd4, d); chk("R9 recorded", d, 8'h01);
    rd(3'd4, d); chk("R9 relatch active", d, 8'h01);
    rerr_in = 7'h00; step(1);
    rd(3'd4, d); chk("R9 sticky", d, 8'h01);
    rd(3'd4, d); chk("R9 cleared", d, 8'h00);
    wr(3'd5, 8'h00);
    clean();
  endtask

  task automatic t_hold();
    logic [7:0] d;
    wr(3'd1, 8'h5A); rd(3'd1, d);
    wr(3'd1, 8'hFF);
    evt_src = 8'hFF; step(3);
    chk("R12 rdata held", reg_rdata, 8'h5A);
    clean();
  endtask

  task automatic t_hist();
    logic [7:0] d;
    @(negedge clk); rst_n = 1'b0; evt_src[6] = 1'b1;
    step(2);
    rst_n = 1'b1;
    step(1);
    chk("R11 irq masked", {7'd0, irq}, 8'h00);
    rd(3'd0, d); chk("R11 rise at release", d, 8'h40);
    evt_src = '0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_regmap();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_rdclr();
    t_mask();
    t_rerr();
    t_hold();
    t_hist();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule